// File: doc/BRIEF.md
# Truncating Floating-Point Adder

This block adds two numbers held in a compact sign/exponent/fraction floating-point format and returns their sum one clock after a start strobe. Before anything else, the operand with the larger magnitude is placed in front. The other operand's significand is then shifted right to line up with it, the two significands are added or subtracted, and the result is brought back to normal form. The shift amount for that last step comes from a leading-zero count made in one combinational pass, not from shifting one place at a time.

Small operands are handled throughout. Operands with an exponent field of zero are taken as they are, and a result too small for a normal exponent is delivered as a denormal. Nothing is rounded: any bit that is shifted out during alignment, or dropped when a carry shifts the sum right, is simply lost. An exponent field of all ones on an input is outside the block's range. A sum that would reach that exponent is clamped to the largest finite magnitude.

Top module: `fp_trunc_adder`

## Requirements
- R1: A word is {sign at bit EXP_W+MAN_W, biased exponent in the EXP_W bits below it, fraction in the low MAN_W bits}. A non-zero exponent field means a hidden leading one. An exponent field of 0 means there is no hidden bit and the exponent used is 1. Operands with an all-ones exponent field are not applied.
- R2: `valid` is high in exactly the cycle after a cycle with `start` high. `sum` changes only in that cycle and holds its value at all other times.
- R3: While reset is asserted, `valid` is 0 and `sum` is all zeros.
- R4: The smaller-magnitude operand's significand is shifted right by the difference of the used exponents before the add. The bits shifted out are discarded with no rounding, and a difference of MAN_W+1 or more leaves nothing of it.
- R5: When the signs match, the significands are added. A carry out shifts the sum right by one place, dropping its lowest bit, and raises the exponent by one.
- R6: If a carry would raise the exponent to all ones, the result is the largest finite value (exponent all ones minus one, fraction all ones) with the sign of the larger operand.
- R7: When the signs differ, the smaller magnitude is subtracted from the larger, and the result carries the sign of the larger-magnitude operand.
- R8: A result whose magnitude is zero, including the exact cancellation of equal magnitudes with opposite signs, is delivered as positive zero (all bits 0).
- R9: A result without a carry is shifted left by its leading-zero count, and the exponent is lowered by the same amount. The shift stops once the exponent reaches 1. If the leading bit is still 0 at that point, the result is emitted as a denormal with an exponent field of 0.
- R10: Denormal operands add correctly, including two denormals whose sum carries into the hidden-bit position and so becomes a normal number with an exponent field of 1.
- R11: Swapping the two operands gives a bit-identical result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Samples the operands at this edge |
| op_a | input | 1+EXP_W+MAN_W | First operand |
| op_b | input | 1+EXP_W+MAN_W | Second operand |
| sum | output | 1+EXP_W+MAN_W | Registered truncated sum |
| valid | output | 1 | One-cycle pulse marking a new sum |

## Verification
The bench aims at the points where a truncating adder goes wrong quietly. A sum that rounds instead of truncating gains an extra unit in the last place when the aligned or carried-out bits are non-zero. Normalization that ignores exponent headroom underflows the exponent, or emits a hidden-bit-less value with a non-zero exponent field, when a subtraction lands in the denormal range. Two denormals that carry into the hidden position can be left with exponent 0 by mistake. Mistakes also show up as negative zero after cancellation, the wrong sign when the smaller operand comes first, a wrapped exponent instead of saturation, and a result that changes when the operands are swapped.

// File: rtl/fp_trunc_adder.sv
module fp_trunc_adder #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [EXP_W+MAN_W:0]     op_a,
  input  logic [EXP_W+MAN_W:0]     op_b,
  output logic [EXP_W+MAN_W:0]     sum,
  output logic                     valid
);
  localparam int W   = 1 + EXP_W + MAN_W;
  localparam int SW  = MAN_W + 1;
  localparam int LZW = $clog2(SW + 1);
  localparam int CW  = (EXP_W > LZW) ? EXP_W : LZW;
  localparam logic [EXP_W-1:0] EXP_ALL = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_BIG = EXP_ALL - 1'b1;

  function automatic logic [LZW-1:0] count_lz(input logic [SW-1:0] v);
    logic [LZW-1:0] n;
    logic hit;
    n = '0;
    hit = 1'b0;
    for (int i = SW - 1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      n = n + 1'b1;
      end
    end
    return n;
  endfunction

  wire a_first = op_a[W-2:0] >= op_b[W-2:0];
  wire [W-1:0] big = a_first ? op_a : op_b;
  wire [W-1:0] sml = a_first ? op_b : op_a;
  wire sign_l  = big[W-1];
  wire eff_sub = op_a[W-1] ^ op_b[W-1];

  wire [EXP_W-1:0] fld_l = big[W-2:MAN_W];
  wire [EXP_W-1:0] fld_s = sml[W-2:MAN_W];
  wire [EXP_W-1:0] exp_l = (fld_l == '0) ? EXP_W'(1) : fld_l;
  wire [EXP_W-1:0] exp_s = (fld_s == '0) ? EXP_W'(1) : fld_s;
  wire [SW-1:0] sig_l = {|fld_l, big[MAN_W-1:0]};
  wire [SW-1:0] sig_s = {|fld_s, sml[MAN_W-1:0]};

  wire [EXP_W-1:0] ediff = exp_l - exp_s;
  wire [SW-1:0] sig_al = (ediff >= EXP_W'(SW)) ? '0 : (sig_s >> ediff);

  wire [SW:0] raw = eff_sub ? ({1'b0, sig_l} - {1'b0, sig_al})
                            : ({1'b0, sig_l} + {1'b0, sig_al});
  wire carry = raw[SW];

  wire [CW-1:0] lz    = CW'(count_lz(raw[SW-1:0]));
  wire [CW-1:0] room  = CW'(exp_l) - 1'b1;
  wire [CW-1:0] sh    = (lz <= room) ? lz : room;
  wire [SW-1:0] norm  = raw[SW-1:0] << sh;
  wire [CW-1:0] exp_n = CW'(exp_l) - sh;

  wire [EXP_W:0] exp_c = {1'b0, exp_l} + 1'b1;
  wire sat = exp_c >= {1'b0, EXP_ALL};

  logic [W-1:0] res;
  always_comb begin
    if (raw == '0)
      res = '0;
    else if (carry)
      res = sat ? {sign_l, EXP_BIG, {MAN_W{1'b1}}}
                : {sign_l, exp_c[EXP_W-1:0], raw[MAN_W:1]};
    else
      res = {sign_l, norm[MAN_W] ? exp_n[EXP_W-1:0] : EXP_W'(0), norm[MAN_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= start;
      if (start) sum <= res;
    end
  end
endmodule

// File: rtl/fp_trunc_adder_chk.sv
module fp_trunc_adder_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [EXP_W+MAN_W:0] op_a,
  input logic [EXP_W+MAN_W:0] op_b,
  input logic [EXP_W+MAN_W:0] sum,
  input logic                 valid
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [EXP_W-1:0] EXP_ALL = {EXP_W{1'b1}};

  assert_valid_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);

  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);

  assert_sum_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(sum));

  assert_no_top_exp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_a[W-2:MAN_W] != EXP_ALL && op_b[W-2:MAN_W] != EXP_ALL)
    |=> sum[W-2:MAN_W] != EXP_ALL);

  assert_cancel_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_a[W-2:0] == op_b[W-2:0] && op_a[W-1] != op_b[W-1])
    |=> sum == '0);

  assert_zero_positive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && sum[W-2:0] == '0) |-> !sum[W-1]);
endmodule

bind fp_trunc_adder fp_trunc_adder_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
  .sum(sum), .valid(valid)
);

// File: tb/tb_fp_trunc_adder.sv
module tb_fp_trunc_adder;
  localparam int EW = 8;
  localparam int MW = 10;
  localparam int W  = 1 + EW + MW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] sum;
  logic valid;

  int checks = 0;
  int failures = 0;
  logic start_q = 1'b0;
  logic [W-1:0] ref_sum = '0;
  logic [W-1:0] keep;

  always #10 clk = ~clk;

  fp_trunc_adder #(.EXP_W(EW), .MAN_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .sum(sum), .valid(valid)
  );

  function automatic logic [W-1:0] fpv(input logic s, input int e, input int f);
    return {s, e[EW-1:0], f[MW-1:0]};
  endfunction

  // behavioural reference: integers, loop normalisation
  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    int ea, eb, ma, mb, r, e, d;
    logic sa, sb, s;
    logic [31:0] rv, ev;
    if (b[W-2:0] > a[W-2:0]) begin
      logic [W-1:0] t;
      t = a; a = b; b = t;
    end
    sa = a[W-1]; sb = b[W-1];
    ea = int'(a[W-2:MW]); eb = int'(b[W-2:MW]);
    ma = int'(a[MW-1:0]) + ((ea != 0) ? (1 << MW) : 0);
    mb = int'(b[MW-1:0]) + ((eb != 0) ? (1 << MW) : 0);
    if (ea == 0) ea = 1;
    if (eb == 0) eb = 1;
    d = ea - eb;
    mb = (d > 30) ? 0 : (mb >> d);
    r = (sa != sb) ? ma - mb : ma + mb;
    e = ea;
    s = sa;
    if (r == 0) return '0;
    if (r >= (2 << MW)) begin
      r = r >> 1;
      e = e + 1;
      if (e >= (1 << EW) - 1) return {s, {(EW-1){1'b1}}, 1'b0, {MW{1'b1}}};
    end
    while (r < (1 << MW) && e > 1) begin
      r = r << 1;
      e = e - 1;
    end
    rv = 32'(r);
    ev = 32'(e);
    if (r < (1 << MW)) return {s, {EW{1'b0}}, rv[MW-1:0]};
    return {s, ev[EW-1:0], rv[MW-1:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  // reference pipeline, compared on every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      ref_sum <= '0;
    end else begin
      start_q <= start;
      if (start) ref_sum <= model(op_a, op_b);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(valid == start_q, "R2 valid", {{(W-1){1'b0}}, valid}, {{(W-1){1'b0}}, start_q});
      check(sum == ref_sum, "R2 sum vs model", sum, ref_sum);
    end
  end

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [W-1:0] expv, input bit lit, input string req);
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0;
    op_a = ~a; op_b = ~b;
    #1;
    if (lit) check(sum == expv, req, sum, expv);
    keep = sum;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] r1;
    repeat (3) @(negedge clk);
    check(valid == 1'b0 && sum == '0, "R3 reset state", sum, '0);
    rst_n = 1'b1;

    // R5 plain add and carry
    run(fpv(0,127,0), fpv(0,127,0), fpv(0,128,0), 1, "R5 1+1");
    run(fpv(0,127,512), fpv(0,127,768), fpv(0,128,640), 1, "R5 1.5+1.75");
    run(fpv(0,127,1), fpv(0,127,0), fpv(0,128,0), 1, "R5 carry drops lsb");
    // R4 alignment truncation
    run(fpv(0,127,0), fpv(0,116,1023), fpv(0,127,0), 1, "R4 fully shifted out");
    run(fpv(0,127,0), fpv(0,126,1), fpv(0,127,512), 1, "R4 truncated lsb");
    // R7 sign of larger
    run(fpv(0,127,0), fpv(1,128,0), fpv(1,127,0), 1, "R7 -2+1");
    run(fpv(1,128,0), fpv(0,127,0), fpv(1,127,0), 1, "R7 order swapped");
    // R8 cancellation
    run(fpv(1,127,0), fpv(0,127,0), '0, 1, "R8 -1+1");
    run(fpv(1,0,5), fpv(0,0,5), '0, 1, "R8 denormal cancel");
    run(fpv(1,0,0), fpv(1,0,0), '0, 1, "R8 neg zeros");
    // R6 saturation
    run(fpv(0,254,1023), fpv(0,254,1023), fpv(0,254,1023), 1, "R6 saturate pos");
    run(fpv(1,254,0), fpv(1,254,0), fpv(1,254,1023), 1, "R6 saturate neg");
    // R9 normalisation clamp to denormal
    run(fpv(0,1,1), fpv(1,0,1023), fpv(0,0,2), 1, "R9 result denormal");
    run(fpv(0,130,0), fpv(1,129,1023), fpv(0,120,0), 1, "R9 deep normalise");
    run(fpv(0,127,0), fpv(1,126,1023), fpv(0,117,0), 1, "R9 lz shift");
    // R1 / R10 denormals
    run(fpv(0,0,512), fpv(0,0,512), fpv(0,1,0), 1, "R10 denormals to normal");
    run(fpv(0,0,3), fpv(0,0,4), fpv(0,0,7), 1, "R1 denormal sum");
    run(fpv(0,1,0), fpv(0,0,1), fpv(0,1,1), 1, "R1 effective exp 1");

    // R2 idle: sum held, valid low with changing inputs
    repeat (4) begin
      @(negedge clk);
      op_a = op_a + 19'd77;
      #1 check(sum == keep && !valid, "R2 hold while idle", sum, keep);
    end

    // R11 commutativity
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      if (a[W-2:MW] == '1) a[W-2] = 1'b0;
      if (b[W-2:MW] == '1) b[W-2] = 1'b0;
      run(a, b, '0, 0, "");
      r1 = sum;
      run(b, a, r1, 1, "R11 swapped operands");
    end

    // back-to-back starts, near exponents (model comparison each clock)
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b;
      int ea;
      a = W'($urandom);
      ea = int'(a[W-2:MW]);
      if (ea == 255) begin ea = 254; a[W-2:MW] = 8'd254; end
      b = W'($urandom);
      if (i % 2 == 0) begin
        int eb;
        eb = ea - int'($urandom % 4);
        if (eb < 0) eb = 0;
        b[W-2:MW] = eb[EW-1:0];
      end else if (b[W-2:MW] == '1) b[W-2] = 1'b0;
      @(negedge clk);
      start = 1'b1; op_a = a; op_b = b;
    end
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule